// File: doc/BRIEF.md
# Shared-Datapath Leaky Integrate-and-Fire Neuron Core

This core keeps the membrane potentials of a population of spiking neurons and updates them all through one arithmetic unit that visits the neurons one slot at a time. An incoming event names an input line (axon). The core then walks every neuron and adds the signed synaptic weight stored for that axon and that neuron to the neuron's potential. A separate timestep pulse starts a second kind of walk. In that walk each potential is decayed, compared against a programmable threshold, and, if it crosses, reset. The neuron's index is then translated into a destination address for the network.

Translated addresses collect in a small output queue. The queue drains through a valid/ready port, so a stalled receiver never causes an event to be lost. When the queue fills, the decay walk pauses until room returns. While either walk is running, the input port reports not-ready. All thresholds, decay settings, weights and destination entries are loaded through a single write-only configuration port.

Top module: `lif_core`

## Requirements
- R1: After reset the core is idle (`busy` low, `in_ready` high, `out_valid` low), every potential is zero, the threshold is +32767, decay is fractional with shift 15, the linear step is 0 and the post-fire value is 0.
- R2: An event accepted on axon a (`in_valid` and `in_ready` high at a rising edge) adds the weight w[a][j] to every neuron j. The weight is a 4-bit two's-complement value (-8..7). No neuron fires during this walk.
- R3: Integration saturates at +32767 and -32768 instead of wrapping around; potentials are 16-bit signed.
- R4: In fractional decay (mode value 0), each timestep replaces u with u - (u >>> d), using an arithmetic shift by the configured d.
- R5: In linear decay (mode value 1), each timestep moves u toward zero by the configured step, and the result stops at zero rather than crossing it.
- R6: After decay, a neuron fires only if its potential is strictly greater than the signed threshold. A firing neuron's potential becomes the configured post-fire value; a neuron exactly at the threshold keeps its decayed value.
- R7: Within one timestep, fired neurons are emitted in ascending index order, each as the destination stored in the lookup entry for that neuron.
- R8: No fired event is lost. `out_dest` stays stable while `out_valid` is high and `out_ready` is low, and the timestep walk pauses while the 16-entry queue is full.
- R9: `in_ready` is low whenever a walk is running or `tick` is high. A `tick` and an `in_valid` in the same idle cycle run the timestep walk first; the event is taken afterwards.
- R10: Configuration map: `cfg_sel`=0 selects control words (address 0 threshold, 1 decay mode in bit 0, 2 shift d in bits 3:0, 3 linear step in bits 14:0, 4 post-fire value). `cfg_sel`=1 writes weight bits 3:0 at address {axon[7:0], neuron[7:0]}. `cfg_sel`=2 writes the 16-bit destination for the neuron at address bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration region select |
| cfg_addr | input | 16 | Configuration address within region |
| cfg_wdata | input | 16 | Configuration write data |
| tick | input | 1 | Timestep pulse, starts decay and fire walk |
| in_valid | input | 1 | Input event present |
| in_axon | input | 8 | Axon index of the input event |
| in_ready | output | 1 | Core can accept an input event |
| busy | output | 1 | A walk over the neurons is running |
| out_valid | output | 1 | Queue head holds a fired destination |
| out_dest | output | 16 | Destination address at the queue head |
| out_ready | input | 1 | Receiver accepts the queue head |

## Verification
Two functions can fall in the same cycle. First, a timestep pulse and an input event can arrive together while the core is idle. The bench raises both in one cycle and checks that `in_ready` is low at that moment. The reference model applies decay and firing before the event's weights, so any change in ordering shows up as wrong or missing destinations. Second, the decay walk can fill the queue while the receiver refuses data. Here the bench holds `out_ready` low through a timestep in which every neuron fires, checks that the core stays busy with a stable queue head, and then requires all destinations in index order once the receiver resumes.

// File: rtl/lif_pkg.sv
package lif_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_INTEG = 2'd1,
    SEQ_DECAY = 2'd2
  } seq_e;

  localparam logic [1:0] CFG_REGION_CTL = 2'd0;
  localparam logic [1:0] CFG_REGION_SYN = 2'd1;
  localparam logic [1:0] CFG_REGION_LUT = 2'd2;

  localparam int CTL_THRESH = 0;
  localparam int CTL_MODE   = 1;
  localparam int CTL_SHIFT  = 2;
  localparam int CTL_STEP   = 3;
  localparam int CTL_RSTVAL = 4;

endpackage

// File: rtl/lif_cfg_regs.sv
module lif_cfg_regs #(
  parameter int V_W    = 16,
  parameter int CFG_AW = 16,
  parameter int CFG_DW = 16,
  localparam int SH_W  = $clog2(V_W)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [CFG_AW-1:0]     addr,
  input  logic [CFG_DW-1:0]     wdata,
  output logic signed [V_W-1:0] thresh,
  output logic                  lin_mode,
  output logic [SH_W-1:0]       shift,
  output logic [V_W-2:0]        step,
  output logic signed [V_W-1:0] rst_val
);
  import lif_pkg::*;

  logic signed [V_W-1:0] thresh_q, thresh_d, rstv_q, rstv_d;
  logic                  mode_q, mode_d;
  logic [SH_W-1:0]       shift_q, shift_d;
  logic [V_W-2:0]        step_q, step_d;

  always_comb begin
    thresh_d = thresh_q;
    mode_d   = mode_q;
    shift_d  = shift_q;
    step_d   = step_q;
    rstv_d   = rstv_q;
    if (we) begin
      if (addr == CFG_AW'(CTL_THRESH)) thresh_d = wdata[V_W-1:0];
      if (addr == CFG_AW'(CTL_MODE))   mode_d   = wdata[0];
      if (addr == CFG_AW'(CTL_SHIFT))  shift_d  = wdata[SH_W-1:0];
      if (addr == CFG_AW'(CTL_STEP))   step_d   = wdata[V_W-2:0];
      if (addr == CFG_AW'(CTL_RSTVAL)) rstv_d   = wdata[V_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thresh_q <= {1'b0, {(V_W-1){1'b1}}};
      mode_q   <= 1'b0;
      shift_q  <= SH_W'(V_W-1);
      step_q   <= '0;
      rstv_q   <= '0;
    end else begin
      thresh_q <= thresh_d;
      mode_q   <= mode_d;
      shift_q  <= shift_d;
      step_q   <= step_d;
      rstv_q   <= rstv_d;
    end
  end

  assign thresh   = thresh_q;
  assign lin_mode = mode_q;
  assign shift    = shift_q;
  assign step     = step_q;
  assign rst_val  = rstv_q;

endmodule

// File: rtl/lif_syn_mem.sv
module lif_syn_mem #(
  parameter int N_AX  = 256,
  parameter int N_NEU = 256,
  parameter int W_W   = 4,
  localparam int AX_W  = $clog2(N_AX),
  localparam int IDX_W = $clog2(N_NEU),
  localparam int ROW_W = N_NEU * W_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AX_W-1:0]  wr_ax,
  input  logic [IDX_W-1:0] wr_neu,
  input  logic [W_W-1:0]   wdata,
  input  logic [AX_W-1:0]  rd_ax,
  input  logic [IDX_W-1:0] rd_neu,
  output logic [W_W-1:0]   rd_w
);

  logic [ROW_W-1:0] row_q [N_AX];

  for (genvar a = 0; a < N_AX; a++) begin : g_row
    logic row_en;
    assign row_en = we && (wr_ax == AX_W'(a));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        row_q[a] <= '0;
      end else if (row_en) begin
        row_q[a][wr_neu*W_W +: W_W] <= wdata;
      end
    end
  end

  assign rd_w = row_q[rd_ax][rd_neu*W_W +: W_W];

endmodule

// File: rtl/lif_route_lut.sv
module lif_route_lut #(
  parameter int N_NEU  = 256,
  parameter int DEST_W = 16,
  localparam int IDX_W = $clog2(N_NEU)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DEST_W-1:0] wdata,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DEST_W-1:0] rd_dest
);

  logic [DEST_W-1:0] dest_q [N_NEU];

  for (genvar i = 0; i < N_NEU; i++) begin : g_ent
    logic ent_en;
    assign ent_en = we && (wr_idx == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dest_q[i] <= '0;
      end else if (ent_en) begin
        dest_q[i] <= wdata;
      end
    end
  end

  assign rd_dest = dest_q[rd_idx];

endmodule

// File: rtl/lif_neuron_alu.sv
module lif_neuron_alu #(
  parameter int V_W   = 16,
  parameter int W_W   = 4,
  localparam int SH_W = $clog2(V_W)
) (
  input  logic                  op_decay,
  input  logic signed [V_W-1:0] u,
  input  logic [W_W-1:0]        w,
  input  logic                  lin_mode,
  input  logic [SH_W-1:0]       shift,
  input  logic [V_W-2:0]        step,
  input  logic signed [V_W-1:0] thresh,
  input  logic signed [V_W-1:0] rst_val,
  output logic signed [V_W-1:0] u_next,
  output logic                  fire
);

  localparam logic signed [V_W:0] MAXV = {2'b00, {(V_W-1){1'b1}}};
  localparam logic signed [V_W:0] MINV = {2'b11, {(V_W-1){1'b0}}};

  logic signed [V_W:0]   u_x, w_x, sum, step_x, lin_x;
  logic signed [V_W-1:0] sat_v, frac_v, decayed;

  always_comb begin
    u_x    = {u[V_W-1], u};
    w_x    = {{(V_W+1-W_W){w[W_W-1]}}, w};
    sum    = u_x + w_x;
    if (sum > MAXV)      sat_v = MAXV[V_W-1:0];
    else if (sum < MINV) sat_v = MINV[V_W-1:0];
    else                 sat_v = sum[V_W-1:0];

    frac_v = u - (u >>> shift);

    step_x = {2'b00, step};
    if (u_x > step_x)       lin_x = u_x - step_x;
    else if (u_x < -step_x) lin_x = u_x + step_x;
    else                    lin_x = '0;

    decayed = lin_mode ? lin_x[V_W-1:0] : frac_v;
    fire    = op_decay && (decayed > thresh);

    if (!op_decay) u_next = sat_v;
    else if (fire) u_next = rst_val;
    else           u_next = decayed;
  end

endmodule

// File: rtl/lif_spike_queue.sv
module lif_spike_queue #(
  parameter int DEPTH = 16,
  parameter int DW    = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  output logic          full,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  input  logic          out_ready
);

  logic [DW-1:0]    slot_q [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pop;

  assign out_valid = (cnt_q != '0);
  assign full      = (cnt_q == CNT_W'(DEPTH));
  assign pop       = out_valid && out_ready;
  assign out_data  = slot_q[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push) wr_d = (wr_q == PTR_W'(DEPTH-1)) ? '0 : wr_q + 1'b1;
    if (pop)  rd_d = (rd_q == PTR_W'(DEPTH-1)) ? '0 : rd_q + 1'b1;
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    logic slot_en;
    assign slot_en = push && (wr_q == PTR_W'(s));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[s] <= '0;
      end else if (slot_en) begin
        slot_q[s] <= push_data;
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R8

  AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R8

endmodule

// File: rtl/lif_core.sv
module lif_core #(
  parameter int N_NEU   = 256,
  parameter int N_AX    = 256,
  parameter int W_W     = 4,
  parameter int V_W     = 16,
  parameter int DEST_W  = 16,
  parameter int Q_DEPTH = 16,
  parameter int CFG_AW  = 16,
  parameter int CFG_DW  = 16,
  localparam int IDX_W  = $clog2(N_NEU),
  localparam int AX_W   = $clog2(N_AX),
  localparam int SH_W   = $clog2(V_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  input  logic              tick,
  input  logic              in_valid,
  input  logic [AX_W-1:0]   in_axon,
  output logic              in_ready,
  output logic              busy,
  output logic              out_valid,
  output logic [DEST_W-1:0] out_dest,
  input  logic              out_ready
);
  import lif_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_NEU-1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  // configuration decode
  logic we_ctl, we_syn, we_lut;
  assign we_ctl = cfg_we && (cfg_sel == CFG_REGION_CTL);
  assign we_syn = cfg_we && (cfg_sel == CFG_REGION_SYN);
  assign we_lut = cfg_we && (cfg_sel == CFG_REGION_LUT);

  logic signed [V_W-1:0] thresh, rst_val;
  logic                  lin_mode;
  logic [SH_W-1:0]       shift;
  logic [V_W-2:0]        step;

  lif_cfg_regs #(.V_W(V_W), .CFG_AW(CFG_AW), .CFG_DW(CFG_DW)) u_cfg (
    .clk(clk), .rst_n(rst_i_n), .we(we_ctl), .addr(cfg_addr), .wdata(cfg_wdata),
    .thresh(thresh), .lin_mode(lin_mode), .shift(shift), .step(step), .rst_val(rst_val)
  );

  // sequencer state
  seq_e             state_q, state_d;
  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic [AX_W-1:0]  ax_q, ax_d;
  logic             step_en, mem_we, push, q_full;

  logic [W_W-1:0]        syn_w;
  logic [DEST_W-1:0]     lut_dest;
  logic signed [V_W-1:0] u_q [N_NEU];
  logic signed [V_W-1:0] u_rd, u_nx;
  logic                  alu_fire;

  lif_syn_mem #(.N_AX(N_AX), .N_NEU(N_NEU), .W_W(W_W)) u_syn (
    .clk(clk), .rst_n(rst_i_n), .we(we_syn),
    .wr_ax(cfg_addr[IDX_W +: AX_W]), .wr_neu(cfg_addr[IDX_W-1:0]),
    .wdata(cfg_wdata[W_W-1:0]),
    .rd_ax(ax_q), .rd_neu(ptr_q), .rd_w(syn_w)
  );

  lif_route_lut #(.N_NEU(N_NEU), .DEST_W(DEST_W)) u_lut (
    .clk(clk), .rst_n(rst_i_n), .we(we_lut),
    .wr_idx(cfg_addr[IDX_W-1:0]), .wdata(cfg_wdata[DEST_W-1:0]),
    .rd_idx(ptr_q), .rd_dest(lut_dest)
  );

  assign u_rd = u_q[ptr_q];

  lif_neuron_alu #(.V_W(V_W), .W_W(W_W)) u_alu (
    .op_decay(state_q == SEQ_DECAY), .u(u_rd), .w(syn_w),
    .lin_mode(lin_mode), .shift(shift), .step(step),
    .thresh(thresh), .rst_val(rst_val), .u_next(u_nx), .fire(alu_fire)
  );

  lif_spike_queue #(.DEPTH(Q_DEPTH), .DW(DEST_W)) u_q_out (
    .clk(clk), .rst_n(rst_i_n), .push(push), .push_data(lut_dest), .full(q_full),
    .out_valid(out_valid), .out_data(out_dest), .out_ready(out_ready)
  );

  assign busy     = (state_q != SEQ_IDLE);
  assign in_ready = (state_q == SEQ_IDLE) && !tick;

  always_comb begin
    state_d = state_q;
    ptr_d   = ptr_q;
    ax_d    = ax_q;
    step_en = 1'b0;
    mem_we  = 1'b0;
    push    = 1'b0;
    case (state_q)
      SEQ_IDLE: begin
        if (tick) begin
          state_d = SEQ_DECAY;
          ptr_d   = '0;
        end else if (in_valid) begin
          state_d = SEQ_INTEG;
          ax_d    = in_axon;
          ptr_d   = '0;
        end
      end
      SEQ_INTEG: begin
        step_en = 1'b1;
        mem_we  = 1'b1;
      end
      SEQ_DECAY: begin
        step_en = !q_full;
        mem_we  = step_en;
        push    = step_en && alu_fire;
      end
      default: state_d = SEQ_IDLE;
    endcase
    if (step_en) begin
      if (ptr_q == LAST_IDX) begin
        state_d = SEQ_IDLE;
        ptr_d   = '0;
      end else begin
        ptr_d = ptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= SEQ_IDLE;
      ptr_q   <= '0;
      ax_q    <= '0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      ax_q    <= ax_d;
    end
  end

  // membrane potentials, one register per neuron
  for (genvar n = 0; n < N_NEU; n++) begin : g_mem
    logic wr_en;
    assign wr_en = mem_we && (ptr_q == IDX_W'(n));
    always_ff @(posedge clk or negedge rst_i_n) begin
      if (!rst_i_n) begin
        u_q[n] <= '0;
      end else if (wr_en) begin
        u_q[n] <= u_nx;
      end
    end
  end

  AST_EVENT_STARTS_WALK: assert property (@(posedge clk) disable iff (!rst_i_n)
    (in_valid && in_ready) |=> (state_q == SEQ_INTEG)); // R2

  AST_TICK_FIRST: assert property (@(posedge clk) disable iff (!rst_i_n)
    (tick && !busy) |=> (state_q == SEQ_DECAY && !in_ready)); // R9

  AST_NO_FIRE_IN_INTEG: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state_q == SEQ_INTEG) |-> !push); // R2

  AST_INTEG_UP: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state_q == SEQ_INTEG && !syn_w[W_W-1]) |-> (u_nx >= u_rd)); // R3

  AST_DECAY_TOWARD_ZERO: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state_q == SEQ_DECAY && !alu_fire && u_rd >= 0) |-> (u_nx >= 0 && u_nx <= u_rd)); // R5

  AST_STALL_ON_FULL: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state_q == SEQ_DECAY && q_full) |=> (state_q == SEQ_DECAY && $stable(ptr_q))); // R8

endmodule

// File: tb/lif_core_test.sv
module lif_core_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [15:0] cfg_addr, cfg_wdata;
  logic        tick, in_valid;
  logic [7:0]  in_axon;
  logic        in_ready, busy, out_valid, out_ready;
  logic [15:0] out_dest;

  always #4 clk = ~clk;

  lif_core uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .tick(tick), .in_valid(in_valid), .in_axon(in_axon),
    .in_ready(in_ready), .busy(busy), .out_valid(out_valid), .out_dest(out_dest),
    .out_ready(out_ready)
  );

  typedef struct {
    logic [15:0] dest;
    string       tag;
  } exp_t;

  exp_t expq[$];
  int   n_checks = 0, n_fails = 0;
  bit   hold_low = 0;
  bit   done = 0;

  int mu[256];
  int wmod[int];
  int thr_m = 32767, mode_m = 0, sh_m = 15, step_m = 0, rstv_m = 0;

  function automatic logic [15:0] lut_of(int j);
    return 16'(32'hA000 + j * 7);
  endfunction

  function automatic int sat16(int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int decay_m(int u);
    if (mode_m == 1) begin
      if (u > step_m) return u - step_m;
      if (u < -step_m) return u + step_m;
      return 0;
    end
    return u - (u >>> sh_m);
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_tick(string tag);
    for (int j = 0; j < 256; j++) begin
      int l;
      exp_t e;
      l = decay_m(mu[j]);
      if (l > thr_m) begin
        e.dest = lut_of(j);
        e.tag  = tag;
        expq.push_back(e);
        mu[j] = rstv_m;
      end else begin
        mu[j] = l;
      end
    end
  endtask

  task automatic model_spike(int a);
    for (int j = 0; j < 256; j++) begin
      int w;
      w = wmod.exists(a * 256 + j) ? wmod[a * 256 + j] : 0;
      mu[j] = sat16(mu[j] + w);
    end
  endtask

  task automatic cfg_write(logic [1:0] sel, int addr, int data);
    cfg_we = 1'b1;
    cfg_sel = sel;
    cfg_addr = 16'(addr);
    cfg_wdata = 16'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_ctl(int addr, int val);
    cfg_write(2'd0, addr, val);
    case (addr)
      0: thr_m = val;
      1: mode_m = val & 1;
      2: sh_m = val & 15;
      3: step_m = val & 16'h7FFF;
      4: rstv_m = val;
      default: ;
    endcase
  endtask

  task automatic set_weight(int a, int n, int w);
    cfg_write(2'd1, a * 256 + n, w & 15);
    wmod[a * 256 + n] = w;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic send_spike(int a);
    bit ok;
    in_valid = 1'b1;
    in_axon = 8'(a);
    do begin
      ok = in_ready;
      @(negedge clk);
    end while (!ok);
    in_valid = 1'b0;
    model_spike(a);
    wait_idle();
  endtask

  task automatic do_tick(string tag);
    model_tick(tag);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    wait_idle();
  endtask

  // receiver: accepts two cycles out of three unless held off
  initial begin
    int rc = 0;
    out_ready = 1'b1;
    forever begin
      @(negedge clk);
      #1;
      rc++;
      out_ready = hold_low ? 1'b0 : ((rc % 3) != 0);
    end
  end

  // monitor: compares every transfer with the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n && out_valid && out_ready) begin
        if (expq.size() == 0) begin
          n_checks++;
          n_fails++;
          $display("FAIL R8 unexpected dest actual=%0d expected=none", out_dest);
        end else begin
          exp_t e;
          e = expq.pop_front();
          check(out_dest == e.dest, {e.tag, " R7 destination"}, int'(out_dest), int'(e.dest));
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cfg_we = 1'b0; cfg_sel = '0; cfg_addr = '0; cfg_wdata = '0;
    tick = 1'b0; in_valid = 1'b0; in_axon = '0;
    foreach (mu[j]) mu[j] = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: idle state after reset
    check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    do_tick("R1");

    // R10: destination table and weights
    for (int j = 0; j < 256; j++) cfg_write(2'd2, j, lut_of(j));
    set_weight(3, 5, 7);
    set_weight(3, 10, -8);
    set_weight(3, 200, 6);
    set_weight(9, 5, 7);
    set_weight(9, 255, 5);
    set_weight(0, 0, 7);

    // R2, R4, R6: fractional decay
    set_ctl(0, 20);
    set_ctl(1, 0);
    set_ctl(2, 2);
    send_spike(3); send_spike(3); send_spike(9); send_spike(3);
    do_tick("R4");
    send_spike(9); send_spike(9); send_spike(9);
    send_spike(0); send_spike(0); send_spike(0);
    do_tick("R6");
    do_tick("R2");

    // R5: linear decay, both signs
    set_ctl(1, 1);
    set_ctl(3, 3);
    set_ctl(0, 10);
    repeat (4) send_spike(3);
    send_spike(9); send_spike(9);
    do_tick("R5");
    do_tick("R5");

    // R6: equality does not fire
    set_ctl(3, 0);
    send_spike(3); send_spike(3);
    set_ctl(0, mu[200]);
    do_tick("R6");

    // R9: tick and event in the same idle cycle
    begin
      bit ok;
      model_tick("R9");
      tick = 1'b1;
      in_valid = 1'b1;
      in_axon = 8'd9;
      #1;
      check(in_ready == 1'b0, "R9 ready with tick", in_ready, 0);
      @(negedge clk);
      tick = 1'b0;
      repeat (10) @(negedge clk);
      check(busy == 1'b1 && in_ready == 1'b0, "R9 ready while busy", in_ready, 0);
      do begin
        ok = in_ready;
        @(negedge clk);
      end while (!ok);
      in_valid = 1'b0;
      model_spike(9);
      wait_idle();
      do_tick("R9");
    end

    // R8: queue fills while receiver stalls; every neuron fires
    set_ctl(4, 32760);
    set_ctl(0, -32768);
    hold_low = 1'b1;
    model_tick("R8");
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    repeat (100) @(negedge clk);
    check(busy == 1'b1, "R8 walk paused", busy, 1);
    check(out_valid == 1'b1, "R8 head valid", out_valid, 1);
    begin
      logic [15:0] head;
      head = out_dest;
      repeat (5) @(negedge clk);
      check(out_dest == head, "R8 head stable", int'(out_dest), int'(head));
    end
    hold_low = 1'b0;
    wait_idle();

    // R3: positive and negative saturation
    set_ctl(0, 32767);
    send_spike(3); send_spike(3);
    set_ctl(0, 32766);
    do_tick("R3");
    set_ctl(4, -32765);
    set_ctl(0, -32768);
    do_tick("R3");
    set_ctl(0, 32767);
    send_spike(3);
    set_ctl(0, -32768);
    do_tick("R3");

    // R8: everything emitted drains
    begin
      int guard = 0;
      while (expq.size() != 0 && guard < 5000) begin
        @(negedge clk);
        guard++;
      end
      repeat (10) @(negedge clk);
      check(expq.size() == 0, "R8 all delivered", expq.size(), 0);
      check(out_valid == 1'b0, "R8 queue empty", out_valid, 0);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule